// File: doc/BRIEF.md
# Multiphase Activation Sequencer

This block chooses which phases of a multiphase buck converter to start each time the output voltage dips below its regulation point. A single activation token circulates around a ring of phase slots. Every rising edge of the under-voltage request starts the phase that holds the token, provided that phase is idle, and then moves the token one slot onward. A phase may start while others are still conducting, so the phases overlap.

When the high-load input is asserted, a rising edge of under-voltage starts every idle phase at the same time instead, and the token stays where it is. Once high-load drops, ordinary one-at-a-time sequencing continues from the slot the token held. Each phase controller reports its own busy status. A busy phase is never restarted. The output is a one-cycle start strobe per phase.

Top module: `buck_phase_sequencer`

## Requirements
- R1: While rst_ni is low, and after it is released, start_o is all zero and the token holds phase 0. The first activation therefore goes to phase 0 (start_o bit 0).
- R2: With hl_i low, a rising edge of uv_i (uv_i high in a cycle after a cycle with uv_i low) raises the start_o bit of the token's phase. The strobe appears in the cycle after uv_i is first sampled high, and no other bit is raised.
- R3: Each activation in normal mode moves the token from phase i to phase i+1. From phase NPH-1 it wraps to phase 0.
- R4: A phase whose busy_i bit is high when the activation is sampled gets no strobe. In normal mode the token still advances past it.
- R5: The busy_i bits of other phases do not block the token phase's strobe, so started phases may overlap.
- R6: Every start_o strobe lasts exactly one cycle.
- R7: A uv_i level held high produces exactly one activation. A new activation needs uv_i to be low for at least one cycle first.
- R8: With hl_i high when the rising edge of uv_i is sampled, start_o raises the bit of every phase whose busy_i bit is low, all in the same cycle.
- R9: An activation taken with hl_i high leaves the token in place. Normal sequencing then resumes from that slot.
- R10: The mode is taken from hl_i in the same cycle that the uv_i edge is sampled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| uv_i | input | 1 | Under-voltage request level |
| hl_i | input | 1 | High-load mode select |
| busy_i | input | NPH | Per-phase busy status from the phase controllers |
| start_o | output | NPH | Per-phase one-cycle start strobe |

## Verification
A change of mode can coincide with an activation. The high-load input can rise or fall in the same cycle as the first high sample of the under-voltage request. The bench provokes this by driving both inputs on one clock edge, in both directions. It judges the result from which strobes appear: a single strobe at the token slot means the normal rule was applied, and all idle phases at once means the high-load rule was applied. The next normal activation then shows whether the token was advanced or held.

// File: rtl/buck_seq_pkg.sv
package buck_seq_pkg;
  typedef enum logic {
    MODE_SEQ = 1'b0,
    MODE_ALL = 1'b1
  } act_mode_e;
endpackage

// File: rtl/uv_edge.sv
module uv_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic rise_o
);
  logic lvl_q;

  // Reset high so a request already asserted at reset release waits for a low cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q <= 1'b1;
    else         lvl_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~lvl_q;
endmodule

// File: rtl/token_ring.sv
module token_ring #(
  parameter int unsigned NPH = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           step_i,
  output logic [NPH-1:0] token_o
);
  for (genvar i = 0; i < NPH; i++) begin : g_slot
    localparam int unsigned PREV = (i == 0) ? NPH - 1 : i - 1;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     token_o[i] <= (i == 0);
      else if (step_i) token_o[i] <= token_o[PREV];
    end
  end
endmodule

// File: rtl/start_gen.sv
module start_gen
  import buck_seq_pkg::*;
#(
  parameter int unsigned NPH = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           fire_i,
  input  act_mode_e      mode_i,
  input  logic [NPH-1:0] token_i,
  input  logic [NPH-1:0] busy_i,
  output logic [NPH-1:0] start_o
);
  logic [NPH-1:0] pick;
  logic [NPH-1:0] start_d;

  always_comb begin
    pick    = (mode_i == MODE_ALL) ? {NPH{1'b1}} : token_i;
    start_d = fire_i ? (pick & ~busy_i) : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) start_o <= '0;
    else         start_o <= start_d;
  end
endmodule

// File: rtl/buck_phase_sequencer.sv
module buck_phase_sequencer
  import buck_seq_pkg::*;
#(
  parameter int unsigned NPH = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           uv_i,
  input  logic           hl_i,
  input  logic [NPH-1:0] busy_i,
  output logic [NPH-1:0] start_o
);
  logic           fire;
  logic           step;
  act_mode_e      mode;
  logic [NPH-1:0] token;

  uv_edge u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  (uv_i),
    .rise_o (fire)
  );

  assign mode = hl_i ? MODE_ALL : MODE_SEQ;
  assign step = fire && (mode == MODE_SEQ);

  token_ring #(.NPH(NPH)) u_ring (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .step_i  (step),
    .token_o (token)
  );

  start_gen #(.NPH(NPH)) u_gen (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .fire_i  (fire),
    .mode_i  (mode),
    .token_i (token),
    .busy_i  (busy_i),
    .start_o (start_o)
  );
endmodule

// File: rtl/buck_phase_sequencer_chk.sv
module buck_phase_sequencer_chk #(
  parameter int unsigned NPH = 4
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           uv_i,
  input logic           hl_i,
  input logic [NPH-1:0] busy_i,
  input logic [NPH-1:0] start_o,
  input logic           fire,
  input logic [NPH-1:0] token
);
  p_token_onehot_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(token) == 1);

  p_token_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && !hl_i) |=> token == {$past(token[NPH-2:0]), $past(token[NPH-1])});

  p_token_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hl_i |=> $stable(token));

  p_pulse_width_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_o != '0) |=> (start_o == '0));

  p_no_busy_start_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_o != '0) |-> ((start_o & $past(busy_i)) == '0));

  p_single_normal_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hl_i |=> $countones(start_o) <= 1);

  p_held_once_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (uv_i && $past(uv_i)) |-> !fire);
endmodule

bind buck_phase_sequencer buck_phase_sequencer_chk #(.NPH(NPH)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .uv_i    (uv_i),
  .hl_i    (hl_i),
  .busy_i  (busy_i),
  .start_o (start_o),
  .fire    (fire),
  .token   (token)
);

// File: tb/buck_phase_sequencer_bench.sv
module buck_phase_sequencer_bench;
  localparam int unsigned NPH = 4;
  localparam time PERIOD = 10ns;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           uv = 1'b0;
  logic           hl = 1'b0;
  logic [NPH-1:0] busy = '0;
  logic [NPH-1:0] start;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(PERIOD / 2) clk = ~clk;

  buck_phase_sequencer #(.NPH(NPH)) u_buck_phase_sequencer (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .uv_i    (uv),
    .hl_i    (hl),
    .busy_i  (busy),
    .start_o (start)
  );

  task automatic check(input logic [NPH-1:0] exp, input string req);
    n_chk++;
    if (start !== exp) begin
      n_fail++;
      $display("FAIL %s: start_o=%b expected %b", req, start, exp);
    end
  endtask

  // One activation: drive uv high with the given mode and busy, check the strobe, then its end
  task automatic uv_pulse(input logic hl_v, input logic [NPH-1:0] busy_v,
                          input logic [NPH-1:0] exp, input string req);
    @(negedge clk);
    uv = 1'b1; hl = hl_v; busy = busy_v;
    @(negedge clk);
    check(exp, req);
    uv = 1'b0;
    @(negedge clk);
    check('0, "R6");
  endtask

  task automatic t_reset;
    check('0, "R1");
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); check('0, "R1");
  endtask

  task automatic t_normal;
    uv_pulse(1'b0, 4'b0000, 4'b0001, "R1");
    uv_pulse(1'b0, 4'b0000, 4'b0010, "R2");
    uv_pulse(1'b0, 4'b0000, 4'b0100, "R3");
    uv_pulse(1'b0, 4'b0000, 4'b1000, "R3");
    uv_pulse(1'b0, 4'b0000, 4'b0001, "R3");  // wrap, token now at 1
  endtask

  task automatic t_busy;
    uv_pulse(1'b0, 4'b0010, 4'b0000, "R4");  // token phase busy, skipped
    uv_pulse(1'b0, 4'b0010, 4'b0100, "R5");  // overlap with busy phase 1
    busy = '0;
  endtask

  task automatic t_held;
    @(negedge clk); uv = 1'b1;
    @(negedge clk); check(4'b1000, "R7");
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); check('0, "R7");
    end
    uv = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_high_load;
    uv_pulse(1'b1, 4'b0100, 4'b1011, "R8");
    uv_pulse(1'b1, 4'b0000, 4'b1111, "R8");
    uv_pulse(1'b0, 4'b0000, 4'b0001, "R9");  // token held at 0
  endtask

  task automatic t_same_cycle;
    hl = 1'b1;
    @(negedge clk);
    uv_pulse(1'b0, 4'b0000, 4'b0010, "R10");  // hl drops with the uv edge
    uv_pulse(1'b1, 4'b0001, 4'b1110, "R10");  // hl rises with the uv edge
    uv_pulse(1'b0, 4'b0000, 4'b0100, "R9");
    hl = 1'b0;
  endtask

  initial begin
    t_reset();
    t_normal();
    t_busy();
    t_held();
    t_high_load();
    t_same_cycle();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #(PERIOD * 20000);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not complete");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule